// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service inside a programmed time window. Each enabled tick passes through a prescaler with a choice of division ratios. The prescaled step then decrements a down-counter whose period is also selectable. The counter stays idle after reset. It loads and begins to count only once software writes a two-byte unlock pattern to the refresh register: first 00h, then FFh. The same pattern, written again while the counter runs, reloads it.

The watchdog fires in two cases. The first is when the counter runs out. The second is when a refresh pattern completes while the count lies outside the permitted window. The window is bounded by two fractions of the period: an upper limit, which sets the earliest allowed refresh, and a lower limit, which sets the latest. A firing event produces a single-cycle pulse on one of two outputs, a reset request or an interrupt, chosen by one control bit. Each of the two causes sets its own sticky status flag. A separate debug register holds a freeze bit that stops all counting while it is set.

All access goes through a simple single-cycle register bus with byte addresses. The register map is:

- 0h: refresh
- 2h: control
- 4h: status
- 6h: output select
- 8h: debug

A separate count-enable input provides the tick.

Top module: `wdt_window_top`

## Requirements
- R1: After reset the control register (2h) reads 3300h, and the status (4h), output-select (6h) and debug (8h) registers read 0. The irqO and rstReqO outputs are low.
- R2: The counter does not move until 00h and then FFh are written to the refresh register (0h). It then holds the reload value, period minus 1, and decrements by one on each prescaled step.
- R3: Any byte other than FFh written to the refresh register after 00h cancels the pattern, and a later FFh alone does nothing. A repeated 00h keeps the pattern armed.
- R4: Control bits [1:0] set the period: 00b gives 1024 (reload 3FFh), 01b gives 4096, 10b gives 8192 and 11b gives 16384 (reload 3FFFh).
- R5: Control bits [7:4] set the prescaler: 0000b divides by 1, 0001b by 4, 0101b by 256, 1000b by 8192, and any other code by 1. Only cycles with cntTickEn high count as ticks.
- R6: A prescaled step taken while the count is 0 fires the watchdog and sets status bit 14. The count stays at 0.
- R7: Control bits [13:12] set the upper window limit: 00b/01b/10b/11b give 25%/50%/75%/100% of the period. Control bits [9:8] set the lower limit: 00b/01b/10b/11b give 75%/50%/25%/0%. A refresh completed while the counter runs is accepted only if lower limit <= count < upper limit. Otherwise it fires the watchdog, sets status bit 15 and freezes the count. A refresh completed while the counter is stopped is always accepted.
- R8: Each firing gives exactly one one-cycle pulse, on rstReqO when bit 7 of register 6h is 1 and on irqO when it is 0. The two outputs are never high together.
- R9: After firing, the counter stays stopped at its value until a new refresh pattern completes.
- R10: While bit 0 of the debug register (8h) is 1, the prescaler and counter hold their values. Clearing the bit lets them resume.
- R11: Writing 0 to status bit 14 or bit 15 clears that flag. Writing 1 leaves it unchanged.
- R12: Status bits [13:0] read back the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntTickEn | input | 1 | Count enable; one tick per cycle while high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| irqO | output | 1 | Interrupt pulse on firing |
| rstReqO | output | 1 | Reset-request pulse on firing |

## Verification
The assertions take two things for granted. First, the bus performs at most one write per cycle. Second, a refresh load and a firing event never fall in the same cycle. The design guarantees the second by giving a rejected refresh precedence over the reload. The stepping checks also assume that the counter changes only through a reload, a single decrement, or not at all, so the bench never forces the counter. The bench moves the design only through bus writes made half a cycle before the clock edge and through the tick input. Each scenario begins from a fresh reset, so no window or prescaler setting carries over into the next.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int TMR_W = 14;  // counter width, fixed by the largest period
  localparam int PS_W  = 13;  // prescaler width, fixed by the largest ratio

  typedef struct packed {
    logic load;  // reload counter and start running
    logic halt;  // stop running, keep count
  } dpCmd_t;

  function automatic logic [TMR_W:0] periodOf(input logic [1:0] sel);
    case (sel)
      2'b00:   return (TMR_W+1)'(1024);
      2'b01:   return (TMR_W+1)'(4096);
      2'b10:   return (TMR_W+1)'(8192);
      default: return (TMR_W+1)'(16384);
    endcase
  endfunction

  function automatic logic [PS_W-1:0] divLastOf(input logic [3:0] code);
    case (code)
      4'b0001: return PS_W'(3);
      4'b0101: return PS_W'(255);
      4'b1000: return PS_W'(8191);
      default: return '0;
    endcase
  endfunction

  // quarters of the period, mult in 0..4
  function automatic logic [TMR_W:0] winLimit(input logic [TMR_W:0] period,
                                               input logic [2:0] mult);
    logic [TMR_W:0] q;
    q = period >> 2;
    case (mult)
      3'd0:    return '0;
      3'd1:    return q;
      3'd2:    return q << 1;
      3'd3:    return q + (q << 1);
      default: return q << 2;
    endcase
  endfunction

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             dbgHold,
  input  dpCmd_t           cmd,
  input  logic [TMR_W-1:0] reloadVal,
  input  logic [PS_W-1:0]  psLast,
  output logic [TMR_W-1:0] cntVal,
  output logic             running,
  output logic             uflowEvt
);

  logic [PS_W-1:0] psCnt;
  logic            stepEn;
  logic            psWrap;

  assign stepEn   = running && !dbgHold && tickEn && !cmd.load && !cmd.halt;
  assign psWrap   = (psCnt >= psLast);
  assign uflowEvt = stepEn && psWrap && (cntVal == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '0;
      psCnt   <= '0;
      running <= 1'b0;
    end else if (cmd.halt) begin
      running <= 1'b0;
    end else if (cmd.load) begin
      cntVal  <= reloadVal;
      psCnt   <= '0;
      running <= 1'b1;
    end else if (stepEn) begin
      if (psWrap) begin
        psCnt <= '0;
        if (cntVal == '0) running <= 1'b0;
        else              cntVal  <= cntVal - 1'b1;
      end else begin
        psCnt <= psCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [TMR_W-1:0]  cntVal,
  input  logic              running,
  input  logic              uflowEvt,
  output dpCmd_t            cmd,
  output logic [TMR_W-1:0]  reloadVal,
  output logic [PS_W-1:0]   psLast,
  output logic              dbgHold,
  output logic              irqO,
  output logic              rstReqO
);

  localparam logic [ADDR_W-1:0] A_REFRESH = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OUTSEL  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_DEBUG   = ADDR_W'(8);
  localparam int UF_BIT  = TMR_W;
  localparam int ERR_BIT = TMR_W + 1;

  logic [1:0] tops, winEnd, winStart;
  logic [3:0] cks;
  logic       rstSel, armed, uflowFlag, errFlag;

  logic [TMR_W:0] period, periodM1, startLim, endLim;
  logic           inWindow, wrRefresh, refreshDone, refreshErr, fireEvt;
  logic           unusedWdata;

  assign unusedWdata = ^{busWdata[DATA_W-1:16], busWdata[11:10], busWdata[3:2]};

  assign period    = periodOf(tops);
  assign periodM1  = period - 1'b1;
  assign reloadVal = periodM1[TMR_W-1:0];
  assign psLast    = divLastOf(cks);
  assign startLim  = winLimit(period, {1'b0, winStart} + 3'd1);
  assign endLim    = winLimit(period, 3'd3 - {1'b0, winEnd});
  assign inWindow  = ({1'b0, cntVal} < startLim) && ({1'b0, cntVal} >= endLim);

  assign wrRefresh   = busWe && (busAddr == A_REFRESH);
  assign refreshDone = wrRefresh && armed && (busWdata[7:0] == 8'hFF);
  assign refreshErr  = refreshDone && running && !inWindow;
  assign cmd.load    = refreshDone && !refreshErr;
  assign cmd.halt    = refreshErr;
  assign fireEvt     = refreshErr || uflowEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tops      <= 2'b00;
      cks       <= 4'b0000;
      winEnd    <= 2'b11;
      winStart  <= 2'b11;
      rstSel    <= 1'b0;
      dbgHold   <= 1'b0;
      armed     <= 1'b0;
      uflowFlag <= 1'b0;
      errFlag   <= 1'b0;
      irqO      <= 1'b0;
      rstReqO   <= 1'b0;
    end else begin
      if (wrRefresh) armed <= (busWdata[7:0] == 8'h00);
      if (busWe && busAddr == A_CTRL) begin
        tops     <= busWdata[1:0];
        cks      <= busWdata[7:4];
        winEnd   <= busWdata[9:8];
        winStart <= busWdata[13:12];
      end
      if (busWe && busAddr == A_OUTSEL) rstSel  <= busWdata[7];
      if (busWe && busAddr == A_DEBUG)  dbgHold <= busWdata[0];

      if (uflowEvt)
        uflowFlag <= 1'b1;
      else if (busWe && busAddr == A_STATUS)
        uflowFlag <= uflowFlag & busWdata[UF_BIT];

      if (refreshErr)
        errFlag <= 1'b1;
      else if (busWe && busAddr == A_STATUS)
        errFlag <= errFlag & busWdata[ERR_BIT];

      irqO    <= fireEvt && !rstSel;
      rstReqO <= fireEvt && rstSel;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL:   busRdata[15:0] = {2'b00, winStart, 2'b00, winEnd, cks, 2'b00, tops};
      A_STATUS: busRdata[ERR_BIT:0] = {errFlag, uflowFlag, cntVal};
      A_OUTSEL: busRdata[7] = rstSel;
      A_DEBUG:  busRdata[0] = dbgHold;
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntTickEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqO,
  output logic              rstReqO
);

  dpCmd_t           cmd;
  logic [TMR_W-1:0] cntVal, reloadVal;
  logic [PS_W-1:0]  psLast;
  logic             running, uflowEvt, dbgHold, loadStb;

  assign loadStb = cmd.load;

  wdt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntVal),
    .running(running), .uflowEvt(uflowEvt), .cmd(cmd),
    .reloadVal(reloadVal), .psLast(psLast), .dbgHold(dbgHold),
    .irqO(irqO), .rstReqO(rstReqO)
  );

  wdt_datapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(cntTickEn), .dbgHold(dbgHold),
    .cmd(cmd), .reloadVal(reloadVal), .psLast(psLast),
    .cntVal(cntVal), .running(running), .uflowEvt(uflowEvt)
  );

endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
  import wdt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             irqO,
  input logic             rstReqO,
  input logic [TMR_W-1:0] cntVal,
  input logic             loadStb,
  input logic             dbgHold,
  input logic             running
);

  // R8: never both outputs
  a_r8_fire_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(irqO && rstReqO));

  // R8: single-cycle pulse
  a_r8_fire_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (irqO || rstReqO) |=> !(irqO || rstReqO));

  // R9: a firing leaves the counter stopped
  a_r9_stopped_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    (irqO || rstReqO) |-> !running);

  // R10: frozen while debug hold set
  a_r10_hold_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHold && !loadStb) |=> $stable(cntVal));

  // R2: running counter moves by at most one step down
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (running && !loadStb) |=>
      (cntVal == $past(cntVal) || cntVal == $past(cntVal) - 1'b1));

endmodule

bind wdt_window_top wdt_window_chk u_chk (
  .clk(clk), .rstN(rstN), .irqO(irqO), .rstReqO(rstReqO),
  .cntVal(cntVal), .loadStb(loadStb), .dbgHold(dbgHold), .running(running)
);

// File: tb/tb_wdt_window_top.sv
module tb_wdt_window_top;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cntTickEn = 1'b0;
  logic              busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              irqO, rstReqO;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  wdt_window_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .cntTickEn(cntTickEn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqO(irqO), .rstReqO(rstReqO)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWe = 1'b0; cntTickEn = 1'b1;
    waitCyc(2);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic refreshSeq();
    busWrite(4'h0, 32'h00);
    busWrite(4'h0, 32'hFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    busRead(4'h2, d); check("R1 ctrl", d, 32'h3300);
    busRead(4'h4, d); check("R1 status", d, 0);
    busRead(4'h6, d); check("R1 outsel", d, 0);
    busRead(4'h8, d); check("R1 debug", d, 0);
    check("R1 outputs", {irqO, rstReqO}, 0);
    waitCyc(50);
    busRead(4'h4, d); check("R2 idle before pattern", d, 0);
  endtask

  task automatic t_start();
    logic [31:0] d;
    doReset();
    refreshSeq();
    busRead(4'h4, d); check("R12 R2 reload", d, 32'h3FF);
    waitCyc(100);
    busRead(4'h4, d); check("R2 decrement", d, 32'h3FF - 100);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    doReset();
    busWrite(4'h0, 32'h00);
    busWrite(4'h0, 32'h55);
    busWrite(4'h0, 32'hFF);
    waitCyc(20);
    busRead(4'h4, d); check("R3 aborted pattern", d, 0);
    busWrite(4'h0, 32'h00);
    busWrite(4'h0, 32'h00);
    busWrite(4'h0, 32'hFF);
    busRead(4'h4, d); check("R3 repeated 00h", d, 32'h3FF);
  endtask

  task automatic t_tops();
    logic [31:0] d;
    logic [31:0] expv [4] = '{32'h3FF, 32'hFFF, 32'h1FFF, 32'h3FFF};
    for (int i = 0; i < 4; i++) begin
      doReset();
      busWrite(4'h2, 32'h3300 | i);
      refreshSeq();
      busRead(4'h4, d); check("R4 period select", d, expv[i]);
    end
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    doReset(); busWrite(4'h2, 32'h3310); refreshSeq();
    waitCyc(10); busRead(4'h4, d); check("R5 div4", d, 32'h3FF - 2);
    doReset(); busWrite(4'h2, 32'h3350); refreshSeq();
    waitCyc(600); busRead(4'h4, d); check("R5 div256", d, 32'h3FF - 2);
    doReset(); busWrite(4'h2, 32'h3380); refreshSeq();
    waitCyc(8191); busRead(4'h4, d); check("R5 div8192 before", d, 32'h3FF);
    waitCyc(1); busRead(4'h4, d); check("R5 div8192 step", d, 32'h3FE);
    doReset(); busWrite(4'h2, 32'h3330); refreshSeq();
    waitCyc(5); busRead(4'h4, d); check("R5 other code div1", d, 32'h3FF - 5);
    cntTickEn = 1'b0;
    waitCyc(20); busRead(4'h4, d); check("R5 no tick no step", d, 32'h3FF - 5);
    cntTickEn = 1'b1;
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    doReset();
    refreshSeq();
    waitCyc(1023);
    busRead(4'h4, d); check("R6 count zero", d, 0);
    check("R6 no early fire", irqO, 0);
    waitCyc(1);
    check("R6 R8 irq fires", irqO, 1);
    check("R8 no reset request", rstReqO, 0);
    busRead(4'h4, d); check("R6 underflow flag", d, 32'h4000);
    waitCyc(1);
    check("R8 pulse width", irqO, 0);
    waitCyc(50);
    busRead(4'h4, d); check("R9 stays stopped", d, 32'h4000);
    refreshSeq();
    busRead(4'h4, d); check("R9 restart", d, 32'h43FF);
    busWrite(4'h4, 32'hC000);
    busRead(4'h4, d); check("R11 write 1 keeps", d & 32'hC000, 32'h4000);
    busWrite(4'h4, 32'h0000);
    busRead(4'h4, d); check("R11 write 0 clears", d & 32'hC000, 0);
  endtask

  task automatic t_outsel();
    logic [31:0] d;
    doReset();
    busWrite(4'h6, 32'h80);
    busRead(4'h6, d); check("R8 outsel readback", d, 32'h80);
    refreshSeq();
    waitCyc(1024);
    check("R8 reset request", {rstReqO, irqO}, 2'b10);
    waitCyc(1);
    check("R8 reset pulse ends", rstReqO, 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    doReset();
    busWrite(4'h2, 32'h1200);  // upper 50%, lower 25%
    refreshSeq();
    waitCyc(100);
    refreshSeq();               // count 922, above upper limit 512
    check("R7 early refresh fires", irqO, 1);
    busRead(4'h4, d); check("R7 error flag, count frozen", d, 32'h8000 | 922);
    waitCyc(10);
    busRead(4'h4, d); check("R9 halted value kept", d, 32'h8000 | 922);
    refreshSeq();
    check("R7 stopped refresh no fire", irqO, 0);
    busRead(4'h4, d); check("R7 stopped refresh loads", d, 32'h8000 | 32'h3FF);
    waitCyc(600);
    refreshSeq();               // count 422, inside window
    check("R7 in-window no fire", irqO, 0);
    busRead(4'h4, d); check("R7 in-window reload", d, 32'h8000 | 32'h3FF);
    waitCyc(900);
    refreshSeq();               // count 122, below lower limit 256
    check("R7 late refresh fires", irqO, 1);
    busRead(4'h4, d); check("R7 late count frozen", d, 32'h8000 | 122);
    busWrite(4'h4, 32'h0);
    busRead(4'h4, d); check("R11 error flag cleared", d, 122);
  endtask

  task automatic t_debug();
    logic [31:0] d;
    doReset();
    refreshSeq();
    waitCyc(10);
    busWrite(4'h8, 32'h1);
    busRead(4'h8, d); check("R10 debug readback", d, 1);
    busRead(4'h4, d); check("R10 count at freeze", d, 32'h3F4);
    waitCyc(100);
    busRead(4'h4, d); check("R10 frozen", d, 32'h3F4);
    busWrite(4'h8, 32'h0);
    waitCyc(10);
    busRead(4'h4, d); check("R10 resumes", d, 32'h3F4 - 10);
  endtask

  initial begin
    t_reset();
    t_start();
    t_abort();
    t_tops();
    t_prescale();
    t_underflow();
    t_outsel();
    t_window();
    t_debug();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule